// File: doc/BRIEF.md
# Two-level loop DMA address engine

This block is the address generator and beat sequencer for a single DMA channel. A descriptor is loaded into it in one cycle. The descriptor holds a source and a destination address, a coded beat size for each side, a signed 16-bit step for each side, a byte count for the inner (minor) loop, an outer (major) iteration count and its reload value, an end-of-transfer adjustment for each address, and the interrupt and request-disable options.

Each trigger runs one minor loop. A trigger is either a software start pulse, or a hardware request while the channel's request enable is set. A minor loop is a sequence of beats, and each beat is one read followed by one write of the data that was read. After every beat, each address moves by its signed step, so a step of zero keeps a peripheral register address fixed.

At the end of a minor loop the major count goes down by one. When the count runs out, the engine adds the two end adjustments, marks the channel done and reloads the count. It can also pulse a completion interrupt and clear the request enable. Illegal configurations and bus error responses stop the channel and raise an error flag that carries the channel number.

Top module: `dma_loop_engine`

## Requirements
- R1: After synchronous reset, rd_req, wr_req, active, done, req_en, irq_major, irq_half and all error flags are 0.
- R2: Size codes give the beat width in bytes: 0 is 1, 1 is 2, 2 is 4, 4 is 16 and 5 is 32. Codes 3, 6 and 7 are illegal. rd_size and wr_size carry the codes. A minor loop issues minor_bytes / width beats. Each beat is a read whose address stays stable until rd_ack, then a write of the data that was read.
- R3: After each beat, the source address adds the sign-extended source step and the destination address adds the sign-extended destination step. A step of 0 leaves that address unchanged.
- R4: Each completed minor loop lowers cur_count by one. Addresses are not reset between minor loops.
- R5: With d_link_en = 0, the count is {d_cur_hi, d_cur_lo} and can reach 32767. With d_link_en = 1, the count is d_cur_lo alone and d_cur_hi is ignored. The reload value {d_beg_hi, d_beg_lo} follows the same rule.
- R6: The last beat of the last minor loop adds both its step and the end adjustment (d_src_last, d_dst_last) to its address. At that point done becomes 1, active becomes 0 and cur_count is reloaded with the begin count.
- R7: irq_major pulses for one cycle at major completion when d_irq_major_en is set. irq_half pulses at the end of the minor loop after which the count equals floor(begin / 2), when d_irq_half_en is set. With both enables clear, neither pulses.
- R8: A minor loop is triggered by sw_start, or by hw_req while req_en is 1. req_en_set sets req_en. When d_req_disable is set, req_en is cleared at major completion, and hw_req then starts no further beats. A trigger that arrives while a minor loop is running is ignored.
- R9: A trigger is rejected and err_cfg is set, with no read issued and active at 0, if any of these holds: the source size code is illegal, the two codes differ, either address is not aligned to the beat width, the minor byte count is zero or not a multiple of the width, or the count is zero.
- R10: An error response on a read sets err_src_bus, and that beat's write is not issued. An error response on a write sets err_dst_bus, and that beat's addresses and the count are not updated. Either error stops the channel with active at 0.
- R11: active is 1 from the first beat until major completion, including between minor loops. A new minor loop clears done. err_chan equals CHAN_ID while any error flag is set. A load, which is accepted only while no minor loop runs, clears done, active and the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture descriptor fields (idle only) |
| d_src_addr | input | AW | Initial source address |
| d_dst_addr | input | AW | Initial destination address |
| d_src_size | input | 3 | Source beat size code |
| d_dst_size | input | 3 | Destination beat size code |
| d_src_off | input | 16 | Signed source step per beat |
| d_dst_off | input | 16 | Signed destination step per beat |
| d_minor_bytes | input | 32 | Bytes per minor loop |
| d_src_last | input | AW | Source adjustment at major completion |
| d_dst_last | input | AW | Destination adjustment at major completion |
| d_cur_lo | input | 9 | Current count, low bits |
| d_cur_hi | input | 6 | Current count, upper bits (link field) |
| d_beg_lo | input | 9 | Begin count, low bits |
| d_beg_hi | input | 6 | Begin count, upper bits (link field) |
| d_link_en | input | 1 | Link field in use; count limited to low bits |
| d_irq_major_en | input | 1 | Enable completion interrupt |
| d_irq_half_en | input | 1 | Enable half-way interrupt |
| d_req_disable | input | 1 | Clear request enable at completion |
| sw_start | input | 1 | Software trigger pulse |
| hw_req | input | 1 | Hardware request |
| req_en_set | input | 1 | Set request enable |
| rd_req | output | 1 | Read beat request |
| rd_addr | output | AW | Current source address |
| rd_size | output | 3 | Read size code |
| rd_ack | input | 1 | Read response |
| rd_err | input | 1 | Read error with rd_ack |
| rd_data | input | 256 | Read data |
| wr_req | output | 1 | Write beat request |
| wr_addr | output | AW | Current destination address |
| wr_size | output | 3 | Write size code |
| wr_data | output | 256 | Write data |
| wr_ack | input | 1 | Write response |
| wr_err | input | 1 | Write error with wr_ack |
| req_en | output | 1 | Hardware request enable |
| active | output | 1 | Channel active |
| done | output | 1 | Major loop complete |
| cur_count | output | 15 | Current major count |
| irq_major | output | 1 | Completion interrupt pulse |
| irq_half | output | 1 | Half-way interrupt pulse |
| err_cfg | output | 1 | Configuration error |
| err_src_bus | output | 1 | Source bus error |
| err_dst_bus | output | 1 | Destination bus error |
| err_chan | output | 6 | Channel number of the error |

## Verification
The bench runs every legal size code against three step patterns: source incrementing with the destination fixed, source fixed with the destination incrementing, and both decrementing by different amounts. Each pattern is combined with one-beat and three-beat minor loops and with one and three major iterations. This separates a wrong width, a wrong sign extension, a step that is missed or doubled, and an end adjustment applied at the wrong beat. Separate runs cover the extended 512-iteration count against the same fields with the link bit set, request-driven chaining that must stop once the request enable clears, and the half-way interrupt on a count of four. They also cover each configuration error condition on its own, a bus error on the second read and on the first write, and a second start during a running loop.

// File: rtl/dle_pkg.sv
package dle_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} seq_state_t;

  localparam int MAX_BEAT_BYTES = 32;

  function automatic logic [5:0] beat_bytes(input logic [2:0] code);
    case (code)
      3'd0:    beat_bytes = 6'd1;
      3'd1:    beat_bytes = 6'd2;
      3'd2:    beat_bytes = 6'd4;
      3'd4:    beat_bytes = 6'd16;
      3'd5:    beat_bytes = 6'd32;
      default: beat_bytes = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/dle_addr_step.sv
module dle_addr_step #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          finish,
  input  logic [15:0]   off,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] off_ext;
  logic [AW-1:0] adj;

  assign off_ext = {{(AW-16){off[15]}}, off};
  assign adj     = finish ? last : '0;

  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (load)
      addr <= load_val;
    else if (step)
      addr <= addr + off_ext + adj;
  end
endmodule

// File: rtl/dle_major_count.sv
module dle_major_count #(
  parameter int LO_W = 9,
  parameter int HI_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 link_en,
  input  logic [LO_W-1:0]      cur_lo,
  input  logic [HI_W-1:0]      cur_hi,
  input  logic [LO_W-1:0]      beg_lo,
  input  logic [HI_W-1:0]      beg_hi,
  input  logic                 dec,
  output logic [LO_W+HI_W-1:0] count,
  output logic                 is_zero,
  output logic                 last_hit,
  output logic                 half_hit
);
  localparam int CW = LO_W + HI_W;

  logic [CW-1:0] beg_q;
  logic [CW-1:0] cur_in;
  logic [CW-1:0] beg_in;

  assign cur_in   = link_en ? {{HI_W{1'b0}}, cur_lo} : {cur_hi, cur_lo};
  assign beg_in   = link_en ? {{HI_W{1'b0}}, beg_lo} : {beg_hi, beg_lo};
  assign is_zero  = (count == '0);
  assign last_hit = (count == CW'(1));
  assign half_hit = ((count - CW'(1)) == (beg_q >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      beg_q <= '0;
    end else if (load) begin
      count <= cur_in;
      beg_q <= beg_in;
    end else if (dec) begin
      count <= last_hit ? beg_q : count - CW'(1);
    end
  end
endmodule

// File: rtl/dle_seq.sv
module dle_seq
  import dle_pkg::*;
#(
  parameter int DW = 256,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          trigger,
  input  logic          cfg_ok,
  input  logic [5:0]    nbeat,
  input  logic [BW-1:0] minor_bytes,
  input  logic          last_hit,
  input  logic          half_hit,
  input  logic          irq_major_en,
  input  logic          irq_half_en,
  input  logic          req_disable,
  input  logic          rd_ack,
  input  logic          rd_err,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_ack,
  input  logic          wr_err,
  output logic          rd_req,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  output logic          step,
  output logic          finish,
  output logic          dec,
  output logic          idle,
  output logic          req_clear,
  output logic          active,
  output logic          done,
  output logic          irq_major,
  output logic          irq_half,
  output logic          err_cfg,
  output logic          err_src_bus,
  output logic          err_dst_bus
);
  seq_state_t    state_q;
  logic [BW-1:0] remain_q;
  logic [BW-1:0] nbeat_ext;
  logic          beat_end;
  logic          minor_end;

  assign nbeat_ext = {{(BW-6){1'b0}}, nbeat};
  assign idle      = (state_q == S_IDLE);
  assign beat_end  = (state_q == S_WR) && wr_ack && !wr_err;
  assign minor_end = beat_end && (remain_q == nbeat_ext);
  assign step      = beat_end;
  assign dec       = minor_end;
  assign finish    = minor_end && last_hit;
  assign req_clear = finish && req_disable;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      remain_q    <= '0;
      rd_req      <= 1'b0;
      wr_req      <= 1'b0;
      wr_data     <= '0;
      active      <= 1'b0;
      done        <= 1'b0;
      irq_major   <= 1'b0;
      irq_half    <= 1'b0;
      err_cfg     <= 1'b0;
      err_src_bus <= 1'b0;
      err_dst_bus <= 1'b0;
    end else begin
      irq_major <= 1'b0;
      irq_half  <= 1'b0;
      if (load && idle) begin
        done        <= 1'b0;
        active      <= 1'b0;
        err_cfg     <= 1'b0;
        err_src_bus <= 1'b0;
        err_dst_bus <= 1'b0;
      end
      case (state_q)
        S_IDLE: begin
          if (trigger) begin
            if (!cfg_ok) begin
              err_cfg <= 1'b1;
              active  <= 1'b0;
            end else begin
              state_q  <= S_RD;
              rd_req   <= 1'b1;
              remain_q <= minor_bytes;
              active   <= 1'b1;
              done     <= 1'b0;
            end
          end
        end
        S_RD: begin
          if (rd_ack) begin
            rd_req <= 1'b0;
            if (rd_err) begin
              err_src_bus <= 1'b1;
              active      <= 1'b0;
              state_q     <= S_IDLE;
            end else begin
              wr_data <= rd_data;
              wr_req  <= 1'b1;
              state_q <= S_WR;
            end
          end
        end
        S_WR: begin
          if (wr_ack) begin
            wr_req <= 1'b0;
            if (wr_err) begin
              err_dst_bus <= 1'b1;
              active      <= 1'b0;
              state_q     <= S_IDLE;
            end else if (minor_end) begin
              state_q <= S_IDLE;
              if (last_hit) begin
                done      <= 1'b1;
                active    <= 1'b0;
                irq_major <= irq_major_en;
              end
              if (half_hit) irq_half <= irq_half_en;
            end else begin
              remain_q <= remain_q - nbeat_ext;
              rd_req   <= 1'b1;
              state_q  <= S_RD;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
  import dle_pkg::*;
#(
  parameter int AW      = 32,
  parameter int BW      = 32,
  parameter int LO_W    = 9,
  parameter int HI_W    = 6,
  parameter int CHW     = 6,
  parameter int CHAN_ID = 5,
  parameter int DW      = 8 * MAX_BEAT_BYTES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [AW-1:0]        d_src_addr,
  input  logic [AW-1:0]        d_dst_addr,
  input  logic [2:0]           d_src_size,
  input  logic [2:0]           d_dst_size,
  input  logic [15:0]          d_src_off,
  input  logic [15:0]          d_dst_off,
  input  logic [BW-1:0]        d_minor_bytes,
  input  logic [AW-1:0]        d_src_last,
  input  logic [AW-1:0]        d_dst_last,
  input  logic [LO_W-1:0]      d_cur_lo,
  input  logic [HI_W-1:0]      d_cur_hi,
  input  logic [LO_W-1:0]      d_beg_lo,
  input  logic [HI_W-1:0]      d_beg_hi,
  input  logic                 d_link_en,
  input  logic                 d_irq_major_en,
  input  logic                 d_irq_half_en,
  input  logic                 d_req_disable,
  input  logic                 sw_start,
  input  logic                 hw_req,
  input  logic                 req_en_set,
  output logic                 rd_req,
  output logic [AW-1:0]        rd_addr,
  output logic [2:0]           rd_size,
  input  logic                 rd_ack,
  input  logic                 rd_err,
  input  logic [DW-1:0]        rd_data,
  output logic                 wr_req,
  output logic [AW-1:0]        wr_addr,
  output logic [2:0]           wr_size,
  output logic [DW-1:0]        wr_data,
  input  logic                 wr_ack,
  input  logic                 wr_err,
  output logic                 req_en,
  output logic                 active,
  output logic                 done,
  output logic [LO_W+HI_W-1:0] cur_count,
  output logic                 irq_major,
  output logic                 irq_half,
  output logic                 err_cfg,
  output logic                 err_src_bus,
  output logic                 err_dst_bus,
  output logic [CHW-1:0]       err_chan
);
  logic [15:0]   soff_q, doff_q;
  logic [BW-1:0] nbytes_q;
  logic [AW-1:0] slast_q, dlast_q;
  logic          imaj_q, ihalf_q, dreq_q;
  logic          idle, take_load, trigger, cfg_ok;
  logic          step, finish, dec, req_clear;
  logic          cnt_zero, last_hit, half_hit;
  logic [5:0]    nbeat;
  logic [AW-1:0] amask;
  logic [BW-1:0] bmask;

  assign take_load = load && idle;
  assign trigger   = idle && !load && (sw_start || (hw_req && req_en));
  assign nbeat     = beat_bytes(rd_size);
  assign amask     = {{(AW-6){1'b0}}, nbeat - 6'd1};
  assign bmask     = {{(BW-6){1'b0}}, nbeat - 6'd1};
  assign cfg_ok    = (nbeat != 6'd0) && (rd_size == wr_size) &&
                     ((rd_addr & amask) == '0) && ((wr_addr & amask) == '0) &&
                     (nbytes_q != '0) && ((nbytes_q & bmask) == '0) && !cnt_zero;
  assign err_chan  = (err_cfg || err_src_bus || err_dst_bus) ? CHW'(CHAN_ID) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_size  <= '0;
      wr_size  <= '0;
      soff_q   <= '0;
      doff_q   <= '0;
      nbytes_q <= '0;
      slast_q  <= '0;
      dlast_q  <= '0;
      imaj_q   <= 1'b0;
      ihalf_q  <= 1'b0;
      dreq_q   <= 1'b0;
    end else if (take_load) begin
      rd_size  <= d_src_size;
      wr_size  <= d_dst_size;
      soff_q   <= d_src_off;
      doff_q   <= d_dst_off;
      nbytes_q <= d_minor_bytes;
      slast_q  <= d_src_last;
      dlast_q  <= d_dst_last;
      imaj_q   <= d_irq_major_en;
      ihalf_q  <= d_irq_half_en;
      dreq_q   <= d_req_disable;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      req_en <= 1'b0;
    else if (req_clear)
      req_en <= 1'b0;
    else if (req_en_set)
      req_en <= 1'b1;
  end

  dle_addr_step #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(take_load), .load_val(d_src_addr),
    .step(step), .finish(finish), .off(soff_q), .last(slast_q), .addr(rd_addr)
  );

  dle_addr_step #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(take_load), .load_val(d_dst_addr),
    .step(step), .finish(finish), .off(doff_q), .last(dlast_q), .addr(wr_addr)
  );

  dle_major_count #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst(rst), .load(take_load), .link_en(d_link_en),
    .cur_lo(d_cur_lo), .cur_hi(d_cur_hi), .beg_lo(d_beg_lo), .beg_hi(d_beg_hi),
    .dec(dec), .count(cur_count), .is_zero(cnt_zero),
    .last_hit(last_hit), .half_hit(half_hit)
  );

  dle_seq #(.DW(DW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .load(load), .trigger(trigger), .cfg_ok(cfg_ok),
    .nbeat(nbeat), .minor_bytes(nbytes_q), .last_hit(last_hit), .half_hit(half_hit),
    .irq_major_en(imaj_q), .irq_half_en(ihalf_q), .req_disable(dreq_q),
    .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .wr_ack(wr_ack), .wr_err(wr_err),
    .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
    .step(step), .finish(finish), .dec(dec), .idle(idle), .req_clear(req_clear),
    .active(active), .done(done), .irq_major(irq_major), .irq_half(irq_half),
    .err_cfg(err_cfg), .err_src_bus(err_src_bus), .err_dst_bus(err_dst_bus)
  );
endmodule

// File: rtl/dma_loop_engine_chk.sv
module dma_loop_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic          req_en,
  input logic          active,
  input logic          done,
  input logic          irq_major,
  input logic          err_cfg,
  input logic          err_src_bus
);
  // R2: a beat is read then write, never both requested at once
  a_r2_one_side: assert property (@(posedge clk) disable iff (rst) !(rd_req && wr_req));
  // R2: read request and address hold until acknowledged
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R11: done and active are never both set
  a_r11_done_excl: assert property (@(posedge clk) disable iff (rst) !(done && active));
  // R7: completion interrupt only with done
  a_r7_irq_done: assert property (@(posedge clk) disable iff (rst) irq_major |-> done);
  // R8: request enable drops only at major completion
  a_r8_req_drop: assert property (@(posedge clk) disable iff (rst) $fell(req_en) |-> done);
  // R9: a rejected configuration starts no read
  a_r9_cfg_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(err_cfg) |-> (!rd_req && !active));
  // R10: a failed read is not followed by a write
  a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
    $rose(err_src_bus) |-> !wr_req);
endmodule

bind dma_loop_engine dma_loop_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_loop_engine_bench.sv
module dma_loop_engine_bench;
  localparam int AW = 32;
  localparam int DW = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic load = 0, sw_start = 0, hw_req = 0, req_en_set = 0;
  logic [AW-1:0] d_src_addr = 0, d_dst_addr = 0, d_src_last = 0, d_dst_last = 0;
  logic [2:0] d_src_size = 0, d_dst_size = 0;
  logic [15:0] d_src_off = 0, d_dst_off = 0;
  logic [31:0] d_minor_bytes = 0;
  logic [8:0] d_cur_lo = 0, d_beg_lo = 0;
  logic [5:0] d_cur_hi = 0, d_beg_hi = 0;
  logic d_link_en = 0, d_irq_major_en = 0, d_irq_half_en = 0, d_req_disable = 0;
  logic rd_req, wr_req, rd_ack = 0, rd_err = 0, wr_ack = 0, wr_err = 0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [2:0] rd_size, wr_size;
  logic [DW-1:0] rd_data, wr_data;
  logic req_en, active, done, irq_major, irq_half, err_cfg, err_src_bus, err_dst_bus;
  logic [14:0] cur_count;
  logic [5:0] err_chan;

  assign rd_data = {8{rd_addr}};

  dma_loop_engine u_dma_loop_engine (.*);

  int compared = 0, mismatched = 0;
  int nrd = 0, nwr = 0, ni = 0, nh = 0, data_bad = 0;
  int err_rd_at = -1, err_wr_at = -1;
  logic [31:0] rd_log [64];
  logic [31:0] wr_log [64];
  logic [31:0] last_rd = 0;

  task automatic chk(string req, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // memory responder and monitor
  initial begin
    forever begin
      @(negedge clk);
      rd_ack = rd_req;
      rd_err = rd_req && (nrd == err_rd_at);
      wr_ack = wr_req;
      wr_err = wr_req && (nwr == err_wr_at);
      if (rd_req) begin
        if (nrd < 64) rd_log[nrd] = rd_addr;
        last_rd = rd_addr;
        nrd++;
      end
      if (wr_req) begin
        if (nwr < 64) wr_log[nwr] = wr_addr;
        if (wr_data !== {8{last_rd}}) data_bad++;
        nwr++;
      end
      if (irq_major) ni++;
      if (irq_half) nh++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic do_load();
    nrd = 0; nwr = 0; ni = 0; nh = 0; data_bad = 0;
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic pulse_start();
    sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic wait_writes(int target);
    int t = 0;
    while (nwr < target && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic setup(int code, int s0, int d0, int so, int dof, int nb, int cnt);
    d_src_size = 3'(code); d_dst_size = 3'(code);
    d_src_addr = s0; d_dst_addr = d0;
    d_src_off = 16'(so); d_dst_off = 16'(dof);
    d_minor_bytes = nb;
    d_cur_lo = 9'(cnt); d_beg_lo = 9'(cnt); d_cur_hi = 0; d_beg_hi = 0;
    d_link_en = 0; d_src_last = 32'h40; d_dst_last = -32'sd32;
    d_irq_major_en = 1; d_irq_half_en = 1; d_req_disable = 0;
    err_rd_at = -1; err_wr_at = -1;
  endtask

  task automatic cfg_case(string what);
    do_load();
    pulse_start();
    repeat (4) @(negedge clk);
    chk({"R9 err_cfg ", what}, err_cfg, 1);
    chk({"R9 err_chan ", what}, err_chan, 5);
    chk({"R9 no read ", what}, nrd, 0);
    chk({"R9 inactive ", what}, active, 0);
  endtask

  int codes [5] = '{0, 1, 2, 4, 5};
  int widths [5] = '{1, 2, 4, 16, 32};

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_req", rd_req, 0);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 active", active, 0);
    chk("R1 done", done, 0);
    chk("R1 req_en", req_en, 0);
    chk("R1 irq", {irq_major, irq_half}, 0);
    chk("R1 errors", {err_cfg, err_src_bus, err_dst_bus}, 0);

    // R2 R3 R4 R6 R7 R11 sweep
    for (int ci = 0; ci < 5; ci++)
      for (int oi = 0; oi < 3; oi++)
        for (int mi = 0; mi < 2; mi++)
          for (int ki = 0; ki < 2; ki++) begin
            int b, so, dof, nb, cnt, bpl, beats;
            logic [31:0] ea;
            b = widths[ci];
            so = (oi == 0) ? b : (oi == 1) ? 0 : -b;
            dof = (oi == 0) ? 0 : (oi == 1) ? b : -2 * b;
            nb = (mi == 0) ? b : 3 * b;
            cnt = (ki == 0) ? 1 : 3;
            bpl = nb / b;
            beats = bpl * cnt;
            setup(codes[ci], 32'h1000, 32'h8000, so, dof, nb, cnt);
            do_load();
            chk("R4 count after load", cur_count, cnt);
            for (int l = 0; l < cnt; l++) begin
              pulse_start();
              wait_writes((l + 1) * bpl);
              if (l == 0 && cnt > 1) begin
                chk("R11 active between loops", active, 1);
                chk("R11 done between loops", done, 0);
                chk("R4 decrement", cur_count, cnt - 1);
              end
            end
            chk("R2 read beats", nrd, beats);
            chk("R2 write beats", nwr, beats);
            chk("R2 write data", data_bad, 0);
            chk("R2 size code", rd_size, codes[ci]);
            for (int k = 0; k < beats; k++) begin
              ea = 32'h1000 + k * so;
              chk("R3 read addr", rd_log[k], ea);
              ea = 32'h8000 + k * dof;
              chk("R3 write addr", wr_log[k], ea);
            end
            ea = 32'h1000 + beats * so + 32'h40;
            chk("R6 final src", rd_addr, ea);
            ea = 32'h8000 + beats * dof - 32;
            chk("R6 final dst", wr_addr, ea);
            chk("R6 done", done, 1);
            chk("R6 active", active, 0);
            chk("R6 reload", cur_count, cnt);
            chk("R7 irq_major", ni, 1);
            chk("R7 irq_half", nh, 1);
          end

    // R5 R8 extended count with hardware requests
    setup(0, 32'h100, 32'h200, 1, 1, 1, 0);
    d_cur_hi = 1; d_beg_hi = 1; d_req_disable = 1;
    do_load();
    chk("R5 extended count", cur_count, 512);
    hw_req = 1;
    req_en_set = 1; @(negedge clk); req_en_set = 0;
    wait_writes(512);
    repeat (20) @(negedge clk);
    chk("R8 request beats", nwr, 512);
    chk("R8 req_en cleared", req_en, 0);
    chk("R5 done", done, 1);
    chk("R5 reload", cur_count, 512);

    // R5 link bit limits count to low field
    setup(0, 32'h100, 32'h200, 1, 1, 1, 2);
    d_cur_hi = 1; d_beg_hi = 1; d_link_en = 1; d_req_disable = 1;
    do_load();
    chk("R5 linked count", cur_count, 2);
    req_en_set = 1; @(negedge clk); req_en_set = 0;
    wait_writes(2);
    repeat (10) @(negedge clk);
    chk("R5 linked beats", nwr, 2);
    chk("R8 linked req_en", req_en, 0);
    hw_req = 0;

    // R7 half interrupt at count four
    setup(2, 32'h100, 32'h200, 4, 4, 4, 4);
    do_load();
    pulse_start(); wait_writes(1);
    chk("R7 no half yet", nh, 0);
    pulse_start(); wait_writes(2);
    chk("R7 half at two", nh, 1);
    pulse_start(); wait_writes(3);
    pulse_start(); wait_writes(4);
    chk("R7 single half", nh, 1);
    chk("R7 major", ni, 1);

    // R7 interrupts disabled
    setup(2, 32'h100, 32'h200, 4, 4, 4, 1);
    d_irq_major_en = 0; d_irq_half_en = 0;
    do_load();
    pulse_start(); wait_writes(1);
    chk("R7 disabled irqs", ni + nh, 0);
    chk("R7 done without irq", done, 1);

    // R9 configuration errors
    setup(2, 32'h1002, 32'h8000, 4, 4, 4, 1); cfg_case("src align");
    setup(2, 32'h1000, 32'h8001, 4, 4, 4, 1); cfg_case("dst align");
    setup(2, 32'h1000, 32'h8000, 4, 4, 6, 1); cfg_case("minor multiple");
    setup(3, 32'h1000, 32'h8000, 4, 4, 8, 1); cfg_case("bad code");
    setup(2, 32'h1000, 32'h8000, 4, 4, 4, 1); d_dst_size = 1; cfg_case("size mismatch");
    setup(2, 32'h1000, 32'h8000, 4, 4, 4, 0); cfg_case("zero count");
    setup(2, 32'h1000, 32'h8000, 4, 4, 0, 1); cfg_case("zero bytes");
    // R11 load clears errors
    setup(2, 32'h1000, 32'h8000, 4, 4, 4, 1);
    do_load();
    chk("R11 load clears error", err_cfg, 0);
    chk("R11 err_chan cleared", err_chan, 0);

    // R10 read bus error on second read
    setup(2, 32'h1000, 32'h8000, 4, 4, 12, 1);
    do_load();
    err_rd_at = 1;
    pulse_start();
    repeat (12) @(negedge clk);
    chk("R10 src bus flag", err_src_bus, 1);
    chk("R10 err_chan", err_chan, 5);
    chk("R10 reads", nrd, 2);
    chk("R10 writes", nwr, 1);
    chk("R10 stopped", active, 0);
    chk("R10 not done", done, 0);
    chk("R10 src stepped once", rd_addr, 32'h1004);

    // R10 write bus error on first write
    setup(2, 32'h1000, 32'h8000, 4, 4, 12, 1);
    do_load();
    err_wr_at = 0;
    pulse_start();
    repeat (12) @(negedge clk);
    chk("R10 dst bus flag", err_dst_bus, 1);
    chk("R10 one read", nrd, 1);
    chk("R10 dst unchanged", wr_addr, 32'h8000);
    chk("R10 count unchanged", cur_count, 1);
    chk("R10 inactive", active, 0);

    // R8 start during running loop ignored
    setup(2, 32'h1000, 32'h8000, 4, 4, 12, 2);
    do_load();
    pulse_start();
    @(negedge clk);
    pulse_start();
    wait_writes(3);
    repeat (10) @(negedge clk);
    chk("R8 extra start ignored", nwr, 3);
    chk("R8 one decrement", cur_count, 1);
    chk("R8 still active", active, 1);

    finish_run();
  end
endmodule